// File: doc/BRIEF.md
# Event Counter Bank

A bank of event counters for a memory-mapped control space. Each counter is given an 8-bit event code that picks one line of a wide per-cycle event strobe vector. A counter advances by one in any cycle in which its selected strobe is high, provided that both a single global run bit and the counter's own enable bit are set. The bank keeps counters at a parameterised width, either 48 or 64 bits. When a counter passes its all-ones value, it latches a pending flag, and a level interrupt reports that flag unless the counter is masked.

Software reaches the bank through a simple single-cycle request bus with a 64-bit data path. Control and status registers are 32 bits wide and are returned in the low half of the read data. Each counter occupies one 64-bit slot. Event codes are packed four to a 32-bit word. A filter register holds source and trace-tag settings as plain storage. A version register returns a build-time constant. Read data appears one cycle after the request.

Top module: `pec_bank`

## Requirements
- R1: After reset, every counter is 0, the global run bit and all per-counter enables are 0, every event code is 0xFF, the interrupt mask is all ones, no status bit is pending, the filter register is 0 and `irq_o` is low.
- R2: Counter i advances by exactly one in a cycle where its selected strobe is high, bit 0 of offset 0x1E00 is set, and bit i of offset 0x1E04 is set. Clearing bit 0 of 0x1E00 freezes every counter at once.
- R3: The code for counter i lives in the word at 0x1E80 + 4*(i/4), bits [8*(i%4)+7 : 8*(i%4)]. Writing that word reprograms four counters, and reading it returns their codes.
- R4: A counter whose code is 0xFF, or whose code is above the parameter MAX_EVT, never advances.
- R5: Counter i is read and written as one 64-bit word at 0x1F00 + 8*i. With CNT_W = 48, bits [63:48] read as zero and writes to them are dropped.
- R6: When a counter advances from its all-ones value at CNT_W bits, it becomes 0 and status bit i is set on the same edge.
- R7: A 1 in bit i of the mask at 0x0804 masks counter i. `irq_o` is high exactly when some status bit is pending and its mask bit is 0.
- R8: Status at 0x0808 is read-only. Writing 1 to bit i of 0x080C clears status bit i, and writing 0 leaves it unchanged. If a wrap and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: The filter register at 0x1E08 stores only bit 2, bits [16:6], bits [30:20] and bit 31. Its other bits read as zero.
- R10: Offset 0x1CF0 returns the parameter VERSION. Reads of any undefined or misaligned offset return 0, and writes to them change nothing. 0x080C reads as 0.
- R11: A bus write to a counter in a cycle where that counter would advance loads the written value. The increment in that cycle is dropped, and no status bit is set for it.
- R12: `rdata_o` holds the read result in the cycle after a read request. The result is the state before that edge's updates. Reads of 32-bit registers return zero in bits [63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | EVT_W | Per-cycle event strobes, indexed by event code |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset |
| wdata_i | input | 64 | Write data (32-bit registers use bits [31:0]) |
| rdata_o | output | 64 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt: pending and unmasked overflow |

## Verification
The bench steers a counter to its all-ones value and fires one strobe. A design that wraps at 64 bits instead of 48, or that sets the status bit a cycle late, shows up both in the status readback and in the interrupt level checked on every clock. The bench also writes a counter while its strobe is held high, and it pairs a clear with a wrap on the same bit; a design with the wrong priority reads back the write value plus one, or loses the pending flag. Event codes of 0xFF and of MAX_EVT+1 are driven together with their strobes, so a design that counts them diverges from the model, while MAX_EVT itself must still count. Writes to the upper counter bits, the filter register's reserved bits, the read-only status word and a misaligned counter offset cover storage that should not exist.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned OFS_IMASK = 32'h0804;
  localparam int unsigned OFS_ISTS  = 32'h0808;
  localparam int unsigned OFS_ICLR  = 32'h080C;
  localparam int unsigned OFS_VER   = 32'h1CF0;
  localparam int unsigned OFS_GCTL  = 32'h1E00;
  localparam int unsigned OFS_CEN   = 32'h1E04;
  localparam int unsigned OFS_FILT  = 32'h1E08;
  localparam int unsigned OFS_ETYPE = 32'h1E80;
  localparam int unsigned OFS_CNT   = 32'h1F00;

  localparam logic [31:0] FILT_WMASK = 32'hFFF1_FFC4;
  localparam logic [7:0]  EVT_NONE   = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IMASK,
    SEL_ISTS,
    SEL_ICLR,
    SEL_VER,
    SEL_GCTL,
    SEL_CEN,
    SEL_FILT,
    SEL_ETYPE,
    SEL_CNT
  } sel_e;
endpackage

// File: rtl/pec_decode.sv
module pec_decode
  import pec_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int AW      = 16,
  parameter int IDX_W   = 3
) (
  input  logic [AW-1:0]    addr_i,
  output sel_e             sel_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NUM_ETW = (NUM_CNT + 3) / 4;
  localparam logic [AW-1:0] CNT_SPAN = AW'(8 * NUM_CNT);
  localparam logic [AW-1:0] ETW_SPAN = AW'(4 * NUM_ETW);

  logic [AW-1:0] cnt_off, etw_off;
  assign cnt_off = addr_i - AW'(OFS_CNT);
  assign etw_off = addr_i - AW'(OFS_ETYPE);

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (cnt_off < CNT_SPAN && cnt_off[2:0] == 3'd0) begin
      sel_o = SEL_CNT;
      idx_o = IDX_W'(cnt_off >> 3);
    end else if (etw_off < ETW_SPAN && etw_off[1:0] == 2'd0) begin
      sel_o = SEL_ETYPE;
      idx_o = IDX_W'(etw_off >> 2);
    end else begin
      case (addr_i)
        AW'(OFS_IMASK): sel_o = SEL_IMASK;
        AW'(OFS_ISTS):  sel_o = SEL_ISTS;
        AW'(OFS_ICLR):  sel_o = SEL_ICLR;
        AW'(OFS_VER):   sel_o = SEL_VER;
        AW'(OFS_GCTL):  sel_o = SEL_GCTL;
        AW'(OFS_CEN):   sel_o = SEL_CEN;
        AW'(OFS_FILT):  sel_o = SEL_FILT;
        default:        sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pec_evt_sel.sv
module pec_evt_sel
  import pec_pkg::*;
#(
  parameter int         EVT_W   = 256,
  parameter logic [7:0] MAX_EVT = 8'hCE
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [7:0]       code_i,
  output logic             hit_o
);
  localparam int EIW = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic code_ok;
  assign code_ok = (code_i != EVT_NONE) && (code_i <= MAX_EVT) && (int'(code_i) < EVT_W);
  assign hit_o   = code_ok && evt_i[code_i[EIW-1:0]];
endmodule

// File: rtl/pec_counter.sv
module pec_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // bus write shadows the increment, so no wrap is reported for it
  assign ovf_o = inc_i && !wr_i && (&cnt_q);
  assign cnt_o = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_q)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0)); // R6
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i))); // R11
endmodule

// File: rtl/pec_irq.sv
module pec_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] ovf_i,
  input  logic [NUM_CNT-1:0] clr_i,
  input  logic [NUM_CNT-1:0] mask_i,
  output logic [NUM_CNT-1:0] sts_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] sts_q;

  // a wrap in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | ovf_i;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ~mask_i);

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0)); // R8
  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_i) |=> (($past(ovf_i) & ~sts_q) == '0)); // R6
  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o); // R7
endmodule

// File: rtl/pec_bank.sv
module pec_bank
  import pec_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 48,
  parameter int          EVT_W   = 256,
  parameter logic [7:0]  MAX_EVT = 8'hCE,
  parameter int          AW      = 16,
  parameter logic [31:0] VERSION = 32'h0000_0030
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [63:0]      wdata_i,
  output logic [63:0]      rdata_o,
  output logic             irq_o
);
  localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int NUM_ETW = (NUM_CNT + 3) / 4;

  sel_e             sel;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;

  logic               gctl_q;
  logic [NUM_CNT-1:0] cen_q, mask_q;
  logic [31:0]        filt_q;
  logic [7:0]         code_q [NUM_CNT];
  logic [63:0]        rdata_q, rdata_d;

  logic [NUM_CNT-1:0] hit, inc, cnt_wr, ovf, clr, sts;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [31:0]        etw [NUM_ETW];

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  pec_decode #(.NUM_CNT(NUM_CNT), .AW(AW), .IDX_W(IDX_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .idx_o  (idx)
  );

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q <= 1'b0;
      cen_q  <= '0;
      mask_q <= '1;
      filt_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_GCTL:  gctl_q <= wdata_i[0];
        SEL_CEN:   cen_q  <= wdata_i[NUM_CNT-1:0];
        SEL_IMASK: mask_q <= wdata_i[NUM_CNT-1:0];
        SEL_FILT:  filt_q <= wdata_i[31:0] & FILT_WMASK;
        default: ;
      endcase
    end
  end

  assign clr = (wr && sel == SEL_ICLR) ? wdata_i[NUM_CNT-1:0] : '0;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q[i] <= EVT_NONE;
      else if (wr && sel == SEL_ETYPE && idx == IDX_W'(i / 4))
        code_q[i] <= wdata_i[8*(i%4) +: 8];
    end

    pec_evt_sel #(.EVT_W(EVT_W), .MAX_EVT(MAX_EVT)) u_sel (
      .evt_i  (evt_i),
      .code_i (code_q[i]),
      .hit_o  (hit[i])
    );

    assign inc[i]    = gctl_q && cen_q[i] && hit[i];
    assign cnt_wr[i] = wr && sel == SEL_CNT && idx == IDX_W'(i);

    pec_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[i]),
      .wr_i    (cnt_wr[i]),
      .wdata_i (wdata_i[CNT_W-1:0]),
      .cnt_o   (cnt[i]),
      .ovf_o   (ovf[i])
    );

    AST_NONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q[i] == EVT_NONE) |-> !inc[i]); // R4
  end

  for (genvar w = 0; w < NUM_ETW; w++) begin : g_etw
    for (genvar b = 0; b < 4; b++) begin : g_byte
      if (4 * w + b < NUM_CNT) begin : g_used
        assign etw[w][8*b +: 8] = code_q[4*w+b];
      end else begin : g_pad
        assign etw[w][8*b +: 8] = 8'h00;
      end
    end
  end

  pec_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovf_i  (ovf),
    .clr_i  (clr),
    .mask_i (mask_q),
    .sts_o  (sts),
    .irq_o  (irq_o)
  );

  // read mux
  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_IMASK: rdata_d = 64'(mask_q);
      SEL_ISTS:  rdata_d = 64'(sts);
      SEL_VER:   rdata_d = 64'(VERSION);
      SEL_GCTL:  rdata_d = 64'(gctl_q);
      SEL_CEN:   rdata_d = 64'(cen_q);
      SEL_FILT:  rdata_d = 64'(filt_q);
      SEL_ETYPE: begin
        for (int k = 0; k < NUM_ETW; k++)
          if (idx == IDX_W'(k)) rdata_d = 64'(etw[k]);
      end
      SEL_CNT: begin
        for (int k = 0; k < NUM_CNT; k++)
          if (idx == IDX_W'(k)) rdata_d = 64'(cnt[k]);
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rdata_d : 64'd0;
  end

  assign rdata_o = rdata_q;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> (rdata_o == 64'd0)); // R12
endmodule

// File: tb/tb_pec_bank.sv
`timescale 1ns/1ps
module tb_pec_bank;
  localparam int          NUM_CNT = 8;
  localparam int          CNT_W   = 48;
  localparam int          EVT_W   = 256;
  localparam logic [7:0]  MAX_EVT = 8'hCE;
  localparam int          AW      = 16;
  localparam logic [31:0] VERSION = 32'h0000_0030;
  localparam logic [63:0] CMAX    = (CNT_W == 64) ? 64'hFFFF_FFFF_FFFF_FFFF
                                                  : ((64'd1 << CNT_W) - 64'd1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [EVT_W-1:0] ev = '0;
  logic             req = 1'b0, we = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [63:0]      wdata = '0;
  logic [63:0]      rdata;
  logic             irq;

  always #2 clk = ~clk;

  pec_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W), .MAX_EVT(MAX_EVT),
             .AW(AW), .VERSION(VERSION)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(ev), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // reference model
  logic [63:0]        m_cnt [NUM_CNT];
  logic [7:0]         m_code [NUM_CNT];
  logic [NUM_CNT-1:0] m_cen, m_mask, m_sts;
  logic               m_gctl;
  logic [31:0]        m_filt;
  logic [63:0]        m_rd;
  bit                 m_rd_pend;

  function automatic logic [63:0] model_read(logic [AW-1:0] a);
    logic [31:0] w;
    if (a == 16'h0804) return 64'(m_mask);
    if (a == 16'h0808) return 64'(m_sts);
    if (a == 16'h1CF0) return 64'(VERSION);
    if (a == 16'h1E00) return 64'(m_gctl);
    if (a == 16'h1E04) return 64'(m_cen);
    if (a == 16'h1E08) return 64'(m_filt);
    for (int wi = 0; wi < (NUM_CNT + 3) / 4; wi++) begin
      if (a == 16'h1E80 + 16'(4 * wi)) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (4 * wi + b < NUM_CNT) w[8*b +: 8] = m_code[4*wi+b];
        return 64'(w);
      end
    end
    for (int i = 0; i < NUM_CNT; i++)
      if (a == 16'h1F00 + 16'(8 * i)) return m_cnt[i];
    return 64'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [NUM_CNT-1:0] ovf, clr;
    logic h;
    if (!rst_n) begin
      for (int i = 0; i < NUM_CNT; i++) begin
        m_cnt[i] = 0;
        m_code[i] = 8'hFF;
      end
      m_cen = '0; m_mask = '1; m_sts = '0; m_gctl = 0; m_filt = '0;
      m_rd_pend = 0; m_rd = '0;
    end else begin
      m_rd_pend = req && !we;
      if (m_rd_pend) m_rd = model_read(addr);
      ovf = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
        h = (m_code[i] != 8'hFF) && (m_code[i] <= MAX_EVT) && ev[m_code[i]];
        if (req && we && addr == 16'h1F00 + 16'(8 * i)) m_cnt[i] = wdata & CMAX;
        else if (m_gctl && m_cen[i] && h) begin
          if (m_cnt[i] == CMAX) begin
            m_cnt[i] = 0;
            ovf[i] = 1'b1;
          end else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      clr = (req && we && addr == 16'h080C) ? wdata[NUM_CNT-1:0] : '0;
      m_sts = (m_sts & ~clr) | ovf;
      if (req && we) begin
        if (addr == 16'h0804) m_mask = wdata[NUM_CNT-1:0];
        if (addr == 16'h1E00) m_gctl = wdata[0];
        if (addr == 16'h1E04) m_cen = wdata[NUM_CNT-1:0];
        if (addr == 16'h1E08) m_filt = wdata[31:0] & 32'hFFF1_FFC4;
        for (int i = 0; i < NUM_CNT; i++)
          if (addr == 16'h1E80 + 16'(4 * (i / 4))) m_code[i] = wdata[8*(i%4) +: 8];
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, "/R7 irq"}, 64'(irq), 64'(|(m_sts & ~m_mask)));
      if (m_rd_pend) chk({cur_req, "/R12 rdata"}, rdata, m_rd);
    end
  end

  task automatic bus(logic w, logic [AW-1:0] a, logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_ev(logic w, logic [AW-1:0] a, logic [63:0] d, logic [EVT_W-1:0] e);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; ev = e;
    @(negedge clk);
    req = 1'b0; we = 1'b0; ev = '0;
  endtask

  task automatic rd_all();
    bus(0, 16'h0804, 0); bus(0, 16'h0808, 0); bus(0, 16'h1E00, 0);
    bus(0, 16'h1E04, 0); bus(0, 16'h1E08, 0); bus(0, 16'h1E80, 0);
    bus(0, 16'h1E84, 0);
    for (int i = 0; i < NUM_CNT; i++) bus(0, 16'h1F00 + 16'(8 * i), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk("R1 irq after reset", 64'(irq), 64'd0);
    rd_all();

    // R3 code packing: 0xFF and 0xCF (>MAX_EVT) never count (R4)
    cur_req = "R3";
    bus(1, 16'h1E80, 64'h0000_0000_FF12_1110);
    bus(1, 16'h1E84, 64'h0000_0000_21CF_CE20);
    bus(0, 16'h1E80, 0); bus(0, 16'h1E84, 0);

    // R2 per-counter enables without global run bit: no count
    cur_req = "R2";
    bus(1, 16'h1E04, 64'hFF);
    lfsr = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev = '0;
      ev[8'h10] = lfsr[0]; ev[8'h11] = lfsr[1]; ev[8'h12] = lfsr[2];
      ev[8'hFF] = lfsr[3]; ev[8'h20] = lfsr[4]; ev[8'hCE] = lfsr[5];
      ev[8'hCF] = lfsr[6]; ev[8'h21] = lfsr[7];
    end
    @(negedge clk); ev = '0;
    rd_all();

    // R2/R4 global run on, varied patterns
    cur_req = "R4";
    bus(1, 16'h1E00, 64'h1);
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev = '0;
      ev[8'h10] = lfsr[0]; ev[8'h11] = lfsr[1]; ev[8'h12] = lfsr[2];
      ev[8'hFF] = lfsr[3]; ev[8'h20] = lfsr[4]; ev[8'hCE] = lfsr[5];
      ev[8'hCF] = 1'b1;    ev[8'h21] = lfsr[7];
      if (n == 150) begin
        req = 1'b1; we = 1'b1; addr = 16'h1E04; wdata = 64'h5A;
      end else begin
        req = 1'b0; we = 1'b0;
      end
    end
    @(negedge clk); ev = '0; req = 1'b0; we = 1'b0;
    rd_all();
    cur_req = "R2";
    bus(1, 16'h1E00, 64'h0);
    bus_ev(0, 16'h1F00, 0, {EVT_W{1'b1}});
    bus(0, 16'h1F00, 0);

    // R5 64-bit counter access, upper bits dropped at 48
    cur_req = "R5";
    bus(1, 16'h1F00, 64'hDEAD_BEEF_1234_5678);
    bus(0, 16'h1F00, 0);
    bus(1, 16'h1F38, 64'hFFFF_0000_0000_0001);
    bus(0, 16'h1F38, 0);
    bus(0, 16'h1F04, 0);

    // R6 wrap sets status; R7 mask gating
    cur_req = "R6";
    bus(1, 16'h1E00, 64'h1);
    bus(1, 16'h1E04, 64'hFF);
    bus(1, 16'h1F08, 64'h0000_FFFF_FFFF_FFFF);
    bus_ev(0, 16'h1F08, 0, EVT_W'(1) << 8'h11);
    bus(0, 16'h1F08, 0);
    bus(0, 16'h0808, 0);
    cur_req = "R7";
    bus(1, 16'h0804, 64'hFD);
    bus(0, 16'h0804, 0);
    bus(1, 16'h0804, 64'hFF);
    bus(1, 16'h0804, 64'h00);
    // R8 clear semantics
    cur_req = "R8";
    bus(1, 16'h080C, 64'h0);
    bus(1, 16'h0808, 64'hFF);
    bus(0, 16'h0808, 0);
    bus(1, 16'h080C, 64'h2);
    bus(0, 16'h0808, 0);
    bus(1, 16'h1F08, 64'h0000_FFFF_FFFF_FFFF);
    bus_ev(1, 16'h080C, 64'h2, EVT_W'(1) << 8'h11);
    bus(0, 16'h0808, 0);
    bus(1, 16'h080C, 64'hFF);

    // R11 write beats increment
    cur_req = "R11";
    bus_ev(1, 16'h1F10, 64'h5, EVT_W'(1) << 8'h12);
    bus(0, 16'h1F10, 0);
    bus(1, 16'h1F10, 64'h0000_FFFF_FFFF_FFFF);
    bus_ev(1, 16'h1F10, 64'h0000_FFFF_FFFF_FFFF, EVT_W'(1) << 8'h12);
    bus(0, 16'h0808, 0);
    bus(0, 16'h1F10, 0);

    // R9 filter storage
    cur_req = "R9";
    bus(1, 16'h1E08, 64'hFFFF_FFFF_FFFF_FFFF);
    bus(0, 16'h1E08, 0);
    bus(1, 16'h1E08, 64'h0000_0000_0000_003B);
    bus(0, 16'h1E08, 0);

    // R10 version and undefined offsets
    cur_req = "R10";
    bus(0, 16'h1CF0, 0);
    bus(1, 16'h1234, 64'hFFFF_FFFF_FFFF_FFFF);
    bus(0, 16'h1234, 0);
    bus(0, 16'h080C, 0);
    bus(1, 16'h1E82, 64'hFFFF_FFFF);
    bus(0, 16'h1E80, 0);
    cur_req = "R12";
    rd_all();
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule